// File: doc/BRIEF.md
# Miss Cost Estimator with Adaptive Threshold

This block rates every last-level cache miss by how well the processor hid it. A free-running counter adds up the instructions issued each cycle. When a miss takes a miss-status entry, the counter value is saved in that entry's snapshot register. When the data for that entry comes back, the difference between the counter and the snapshot is the number of instructions issued while the miss was outstanding. A miss under which few instructions issued is high cost. A miss under which many issued is low cost. The result trains a 2-bit saturating counter for the returning line in a direct-mapped history table. The updated counter value is handed to the replacement logic one cycle after the return.

The block also adjusts the boundary between high and low cost. It counts misses and high-cost returns in fixed-length periods. At the end of each period, a two-state controller spends one cycle in `PH_RETUNE` and moves the threshold by a fixed step of 8. Too few high-cost returns raise the threshold, too many lower it, and a count between the two limits leaves it unchanged. The threshold stops at both rails. The controller is otherwise in `PH_ACCUM`. Its transitions are:

- `ACCUM->RETUNE`, taken on the miss that completes the period.
- `RETUNE->ACCUM`, taken unconditionally.

The caller passes the history-table index of the returning block (its low address bits) with the fill strobe. Cache arrays, tag lookup and memory traffic are outside this block.

Top module: `miss_cost_estimator`

## Requirements
- R1: After reset, `cost_vld` is 0 and every history counter holds 1. The threshold equals THR_INIT, and the period miss count and high-cost count are 0.
- R2: The issued count of a fill is the sum of `issue_cnt` over the cycles from the allocation cycle of that slot up to, but not including, the fill cycle.
- R3: The issued count is taken modulo 2^CNT_W, so it stays correct when the counter wraps between allocation and fill.
- R4: A fill whose issued count is strictly below the threshold is high cost. Its history counter rises by one and saturates at 3. Counter values 2 and 3 mean high cost, and 3 and 0 mean high confidence.
- R5: A fill whose issued count is equal to or above the threshold is low cost. Its history counter falls by one and saturates at 0. Counter values 0 and 1 mean low cost.
- R6: `cost_vld` is 1 exactly in the cycle after a `fill_vld` cycle. `cost_val` then carries the counter value after that fill's update.
- R7: The history table is direct-mapped by `fill_line`. A line's counter is kept between fills and is not changed by fills to other lines.
- R8: The controller enters PH_RETUNE for one cycle after the miss that brings the period miss count to PERIOD. A new threshold applies from the following cycle. In PH_RETUNE both period counts restart, and a miss or high-cost fill in that cycle counts toward the new period.
- R9: At retune the threshold rises by 8 if the period's high-cost count is below MIN_HIGH. It falls by 8 if the count is above MAX_HIGH. Otherwise it is unchanged.
- R10: The threshold saturates at 0 and at 2^THR_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_cnt | input | ISSUE_W | Instructions issued this cycle |
| miss_vld | input | 1 | A miss is allocated this cycle |
| miss_slot | input | $clog2(MSHR_N) | Miss-status entry taken by the miss |
| fill_vld | input | 1 | Miss data returns this cycle |
| fill_slot | input | $clog2(MSHR_N) | Miss-status entry being retired |
| fill_line | input | HIST_IDX_W | History index (low block-address bits) of the returning block |
| cost_vld | output | 1 | `cost_val` is valid |
| cost_val | output | 2 | Updated stored cost of the returning block |

## Verification
The bench uses the following parameter values:

| Parameter | Value | Effect |
|---|---|---|
| CNT_W | 8 | The issue counter wraps every few dozen cycles, so many misses straddle the wrap. |
| PERIOD | 4 | Retunes happen every few transactions. |
| THR_W | 6 | The threshold range is 0 to 63. |
| THR_INIT | 20 | The start value is not a multiple of 8, so climbing reaches the upper rail through a clipped step and falling reaches 0 through another. |
| MIN_HIGH, MAX_HIGH | 1 and 2 | A period with exactly one or two high-cost returns exercises the hold case. |
| MSHR_N | 4 | The random phase keeps several misses in flight. |
| HIST_IDX_W | 4 | Sixteen lines let the random phase retrain the same counters repeatedly. |

Directed probes set the issued count to one below, or exactly at, the current threshold, which pins down the strict-less-than boundary at every threshold value reached.

// File: rtl/mce_pkg.sv
package mce_pkg;

    typedef enum logic {
        PH_ACCUM  = 1'b0,
        PH_RETUNE = 1'b1
    } period_ph_e;

    function automatic logic [1:0] cost_step(input logic [1:0] cur, input logic high);
        logic [1:0] nxt;
        if (high) begin
            nxt = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
        end else begin
            nxt = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/mce_issue_tracker.sv
module mce_issue_tracker #(
    parameter int ISSUE_W = 4,
    parameter int CNT_W   = 16,
    parameter int MSHR_N  = 16,
    localparam int SLOT_W = $clog2(MSHR_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ISSUE_W-1:0] issue_i,
    input  logic               alloc_i,
    input  logic [SLOT_W-1:0]  alloc_slot_i,
    input  logic [SLOT_W-1:0]  ret_slot_i,
    output logic [CNT_W-1:0]   elapsed_o
);

    logic [CNT_W-1:0] icnt_q;
    logic [CNT_W-1:0] snap_q [MSHR_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icnt_q <= '0;
            for (int k = 0; k < MSHR_N; k++) begin
                snap_q[k] <= '0;
            end
        end else begin
            icnt_q <= icnt_q + CNT_W'(issue_i);
            if (alloc_i) begin
                snap_q[alloc_slot_i] <= icnt_q;
            end
        end
    end

    // modular difference survives counter wrap
    assign elapsed_o = icnt_q - snap_q[ret_slot_i];

endmodule

// File: rtl/mce_history.sv
module mce_history
    import mce_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int HIST_N = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_i,
    input  logic [IDX_W-1:0] line_i,
    input  logic             high_i,
    output logic             cost_vld_o,
    output logic [1:0]       cost_val_o
);

    logic [1:0] tbl_q [HIST_N];
    logic [1:0] upd;

    assign upd = cost_step(tbl_q[line_i], high_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < HIST_N; k++) begin
                tbl_q[k] <= 2'd1;
            end
            cost_vld_o <= 1'b0;
            cost_val_o <= 2'd0;
        end else begin
            cost_vld_o <= fill_i;
            if (fill_i) begin
                tbl_q[line_i] <= upd;
                cost_val_o    <= upd;
            end
        end
    end

    AST_HIGH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i && high_i |=> cost_val_o != 2'd0); // R4
    AST_LOW_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i && !high_i |=> cost_val_o != 2'd3); // R5
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> cost_vld_o); // R6

endmodule

// File: rtl/mce_threshold.sv
module mce_threshold
    import mce_pkg::*;
#(
    parameter int THR_W    = 8,
    parameter int THR_INIT = 64,
    parameter int PERIOD   = 16384,
    parameter int MIN_HIGH = 2048,
    parameter int MAX_HIGH = 8192,
    parameter int STEP     = 8,
    localparam int CNT_W   = $clog2(PERIOD + 1),
    localparam int TOT_W   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic             high_evt_i,
    output logic [THR_W-1:0] thr_o
);

    localparam logic [CNT_W-1:0] LAST    = CNT_W'(PERIOD - 1);
    localparam logic [TOT_W-1:0] TOT_MAX = '1;
    localparam logic [TOT_W-1:0] MINV    = TOT_W'(MIN_HIGH);
    localparam logic [TOT_W-1:0] MAXV    = TOT_W'(MAX_HIGH);
    localparam logic [THR_W:0]   STEP_X  = (THR_W + 1)'(STEP);
    localparam logic [THR_W:0]   THR_TOP = {1'b0, {THR_W{1'b1}}};

    period_ph_e       ph_q, ph_d;
    logic [CNT_W-1:0] mcnt_q;
    logic [TOT_W-1:0] tot_q;
    logic [THR_W-1:0] thr_q, thr_new, thr_up, thr_dn;
    logic [THR_W:0]   up_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_ACCUM;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_ACCUM:  if (miss_i && mcnt_q == LAST) ph_d = PH_RETUNE;
            PH_RETUNE: ph_d = PH_ACCUM;
        endcase
    end

    assign up_sum = {1'b0, thr_q} + STEP_X;
    assign thr_up = (up_sum > THR_TOP) ? {THR_W{1'b1}} : up_sum[THR_W-1:0];
    assign thr_dn = ({1'b0, thr_q} < STEP_X) ? '0 : thr_q - STEP_X[THR_W-1:0];

    always_comb begin
        if (tot_q < MINV)      thr_new = thr_up;
        else if (tot_q > MAXV) thr_new = thr_dn;
        else                   thr_new = thr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt_q <= '0;
            tot_q  <= '0;
            thr_q  <= THR_W'(THR_INIT);
        end else begin
            unique case (ph_q)
                PH_ACCUM: begin
                    mcnt_q <= mcnt_q + CNT_W'(miss_i);
                    if (high_evt_i && tot_q != TOT_MAX) tot_q <= tot_q + 1'b1;
                end
                PH_RETUNE: begin
                    mcnt_q <= CNT_W'(miss_i);
                    tot_q  <= TOT_W'(high_evt_i);
                    thr_q  <= thr_new;
                end
            endcase
        end
    end

    assign thr_o = thr_q;

    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_ACCUM |=> $stable(thr_q)); // R8
    AST_RETUNE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_RETUNE |=> (mcnt_q <= CNT_W'(1) && ph_q == PH_ACCUM)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mcnt_q <= CNT_W'(PERIOD)); // R8
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_RETUNE |=> (({1'b0, thr_q} + STEP_X >= {1'b0, $past(thr_q)}) &&
                               ({1'b0, $past(thr_q)} + STEP_X >= {1'b0, thr_q}))); // R10

endmodule

// File: rtl/miss_cost_estimator.sv
module miss_cost_estimator #(
    parameter int ISSUE_W    = 4,
    parameter int CNT_W      = 16,
    parameter int MSHR_N     = 16,
    parameter int HIST_IDX_W = 8,
    parameter int THR_W      = 8,
    parameter int THR_INIT   = 64,
    parameter int PERIOD     = 16384,
    parameter int MIN_HIGH   = 2048,
    parameter int MAX_HIGH   = 8192,
    localparam int SLOT_W    = $clog2(MSHR_N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ISSUE_W-1:0]    issue_cnt,
    input  logic                  miss_vld,
    input  logic [SLOT_W-1:0]     miss_slot,
    input  logic                  fill_vld,
    input  logic [SLOT_W-1:0]     fill_slot,
    input  logic [HIST_IDX_W-1:0] fill_line,
    output logic                  cost_vld,
    output logic [1:0]            cost_val
);

    logic [CNT_W-1:0] elapsed;
    logic [THR_W-1:0] thr;
    logic             is_high;

    mce_issue_tracker #(
        .ISSUE_W(ISSUE_W), .CNT_W(CNT_W), .MSHR_N(MSHR_N)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_cnt),
        .alloc_i(miss_vld), .alloc_slot_i(miss_slot),
        .ret_slot_i(fill_slot), .elapsed_o(elapsed)
    );

    assign is_high = elapsed < CNT_W'(thr);

    mce_history #(.IDX_W(HIST_IDX_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .fill_i(fill_vld), .line_i(fill_line),
        .high_i(is_high), .cost_vld_o(cost_vld), .cost_val_o(cost_val)
    );

    mce_threshold #(
        .THR_W(THR_W), .THR_INIT(THR_INIT), .PERIOD(PERIOD),
        .MIN_HIGH(MIN_HIGH), .MAX_HIGH(MAX_HIGH), .STEP(8)
    ) u_thr (
        .clk(clk), .rst_n(rst_n), .miss_i(miss_vld),
        .high_evt_i(fill_vld && is_high), .thr_o(thr)
    );

endmodule

// File: tb/miss_cost_estimator_tb.sv
module miss_cost_estimator_tb;

    localparam int ISSUE_W = 4, CNT_W = 8, MSHR_N = 4, HIST_IDX_W = 4;
    localparam int THR_W = 6, THR_INIT = 20, PERIOD = 4, MIN_HIGH = 1, MAX_HIGH = 2;
    localparam int SLOT_W = $clog2(MSHR_N);
    localparam int HIST_N = 1 << HIST_IDX_W;
    localparam int CMASK = (1 << CNT_W) - 1;
    localparam int TMAX = (1 << THR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ISSUE_W-1:0] issue_cnt = '0;
    logic miss_vld = 1'b0, fill_vld = 1'b0;
    logic [SLOT_W-1:0] miss_slot = '0, fill_slot = '0;
    logic [HIST_IDX_W-1:0] fill_line = '0;
    logic cost_vld;
    logic [1:0] cost_val;

    always #4 clk = ~clk;

    miss_cost_estimator #(
        .ISSUE_W(ISSUE_W), .CNT_W(CNT_W), .MSHR_N(MSHR_N), .HIST_IDX_W(HIST_IDX_W),
        .THR_W(THR_W), .THR_INIT(THR_INIT), .PERIOD(PERIOD),
        .MIN_HIGH(MIN_HIGH), .MAX_HIGH(MAX_HIGH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_cnt(issue_cnt), .miss_vld(miss_vld),
        .miss_slot(miss_slot), .fill_vld(fill_vld), .fill_slot(fill_slot),
        .fill_line(fill_line), .cost_vld(cost_vld), .cost_val(cost_val)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference model
    int m_icnt, m_thr, m_mc, m_th, m_ni, m_h;
    int m_snap [MSHR_N];
    int m_hist [HIST_N];
    bit m_ret, m_hi, e_vld;
    int e_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_icnt = 0; m_thr = THR_INIT; m_mc = 0; m_th = 0; m_ret = 0;
            e_vld = 0; e_val = 0;
            for (int k = 0; k < MSHR_N; k++) m_snap[k] = 0;
            for (int k = 0; k < HIST_N; k++) m_hist[k] = 1;
        end else begin
            m_hi = 0;
            e_vld = fill_vld;
            if (fill_vld) begin
                m_ni = (m_icnt - m_snap[fill_slot]) & CMASK;
                m_hi = (m_ni < m_thr);
                m_h = m_hist[fill_line];
                if (m_hi) m_h = (m_h >= 3) ? 3 : m_h + 1;
                else      m_h = (m_h <= 0) ? 0 : m_h - 1;
                m_hist[fill_line] = m_h;
                e_val = m_h;
            end
            if (miss_vld) m_snap[miss_slot] = m_icnt;
            m_icnt = (m_icnt + int'(issue_cnt)) & CMASK;
            if (m_ret) begin
                if (m_th < MIN_HIGH)      m_thr = (m_thr + 8 > TMAX) ? TMAX : m_thr + 8;
                else if (m_th > MAX_HIGH) m_thr = (m_thr < 8) ? 0 : m_thr - 8;
                m_mc = miss_vld ? 1 : 0;
                m_th = m_hi ? 1 : 0;
                m_ret = 0;
            end else begin
                m_mc += miss_vld ? 1 : 0;
                m_th += m_hi ? 1 : 0;
                if (m_mc == PERIOD) m_ret = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(cost_vld == 1'b0, "R1 reset valid", int'(cost_vld), 0);
            end else begin
                chk(cost_vld == e_vld, "R6 valid timing", int'(cost_vld), int'(e_vld));
                if (e_vld) chk(int'(cost_val) == e_val, cur_req, int'(cost_val), e_val);
            end
        end
    end

    task automatic cyc(input int iss, input bit mv, input int ms, input bit fv,
                       input int fs, input int fl);
        @(negedge clk);
        issue_cnt = ISSUE_W'(iss);
        miss_vld  = mv;
        miss_slot = SLOT_W'(ms);
        fill_vld  = fv;
        fill_slot = SLOT_W'(fs);
        fill_line = HIST_IDX_W'(fl);
    endtask

    // one miss/fill pair with an exact issued count n
    task automatic txn(input int slot, input int line, input int n);
        int rem = n;
        bit first = 1;
        while (first || rem > 0) begin
            int a = (rem > 15) ? 15 : rem;
            cyc(a, first, slot, 0, 0, 0);
            rem -= a;
            first = 0;
        end
        cyc(0, 0, 0, 1, slot, line);
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    bit outst [MSHR_N];

    initial begin
        cur_req = "R1";
        repeat (4) cyc(0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0);
        // fresh lines start at 1: one high fill -> 2, one low fill -> 0
        txn(0, 6, 0);
        txn(1, 7, 40);

        cur_req = "R4 R2 saturate up";
        for (int i = 0; i < 4; i++) txn(i % MSHR_N, 3, (m_thr > 0) ? m_thr - 1 : 0);
        cur_req = "R5 boundary equal, saturate down";
        for (int i = 0; i < 5; i++) txn(i % MSHR_N, 3, m_thr);
        cur_req = "R7 independent lines";
        txn(2, 9, 0);
        txn(3, 10, 60);
        txn(0, 9, 0);
        txn(1, 3, 0);

        cur_req = "R3 wrap";
        for (int i = 0; i < 12; i++) txn(i % MSHR_N, i % HIST_N, 90 + 7 * i);

        cur_req = "R8 R9 R10 rise to top rail";
        for (int i = 0; i < 32; i++) txn(i % MSHR_N, 5, m_thr);
        cur_req = "R9 hold between limits";
        for (int p = 0; p < 3; p++) begin
            txn(0, 1, 0);
            txn(1, 2, 63);
            txn(2, 2, 63);
            txn(3, 2, 63);
        end
        cur_req = "R9 R10 fall to bottom rail";
        for (int i = 0; i < 40; i++) txn(i % MSHR_N, 8, (m_thr > 0) ? m_thr - 1 : 0);

        cur_req = "R2 R3 R6 R8 random traffic";
        for (int k = 0; k < MSHR_N; k++) outst[k] = 0;
        for (int c = 0; c < 4000; c++) begin
            int ms = $urandom_range(0, MSHR_N - 1);
            int fs = $urandom_range(0, MSHR_N - 1);
            bit mv = !outst[ms] && ($urandom_range(0, 3) == 0);
            bit fv = outst[fs] && ($urandom_range(0, 2) == 0);
            cyc($urandom_range(0, 15), mv, ms, fv, fs, $urandom_range(0, HIST_N - 1));
            if (mv) outst[ms] = 1;
            if (fv) outst[fs] = 0;
        end
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule